// File: doc/BRIEF.md
# ISC Ready/Error Status Pins

This block drives the two active-low status pins of an in-system-configuration test port that sits in front of a flash array. A test access port controller sends it single-cycle strobes for three decoded instructions: enter configuration mode, leave configuration mode, and clear error. A flash program/erase engine sends it busy levels and failure pulses. The block turns these into a ready/busy pin and a sticky error pin. The pins are modelled as an output-enable and an output-value pair for each pad.

The ready/busy pin reads high while the array can be read. It reads low while any busy source is active, such as a program or erase cycle or a write to the secondary array. The error pin goes low on the first failure report and stays low. It clears only on a clear-error strobe, or on a chip reset that arrives while configuration mode is off. When configuration mode is entered, an open-drain selection is captured. In open-drain mode a pin is driven only while it is asserted, so that several chained devices can share one wired-OR line.

Top module: `isc_flags`

## Requirements
- R1: After power-on reset (`rst_n` low), both pins are released (`*_oe`=0, `*_val`=1) and the error flag is clear.
- R2: While configuration mode is off, both pins stay released (oe=0, val=1). A pulse on `en_stb` with `dis_stb` low turns the mode on. A pulse on `dis_stb` turns it off.
- R3: In push-pull mode (`od_sel`=0 at enable), `rdy_oe` is 1. `rdy_val` is 0 while any bit of `busy_src` is 1, and 1 otherwise.
- R4: A 1 on any bit of `err_src` sets the error flag. The flag stays set with no further failures. While it is set, an enabled push-pull error pin drives `err_val`=0.
- R5: A pulse on `clr_stb` clears the error flag. If a failure arrives in the same cycle, the flag stays set.
- R6: A pulse on `chip_rst` while configuration mode is on leaves the error flag unchanged.
- R7: A pulse on `chip_rst` while configuration mode is off clears the error flag.
- R8: In open-drain mode (`od_sel`=1 at enable), each pin has val=0 at all times. Its oe is 1 only while the pin is asserted (busy for the ready pin, flag set for the error pin).
- R9: The error flag keeps its value while configuration mode is off. It shows again on the pin after the mode is re-entered.
- R10: When `en_stb` and `dis_stb` pulse in the same cycle, the disable wins and the mode ends off.

Pin outputs follow their inputs by one clock. The mode and the error flag are registered one clock before that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| en_stb | input | 1 | Enter configuration mode strobe |
| dis_stb | input | 1 | Leave configuration mode strobe |
| clr_stb | input | 1 | Clear error strobe |
| od_sel | input | 1 | Open-drain select, captured with `en_stb` |
| chip_rst | input | 1 | Chip reset pulse |
| busy_src | input | BUSY_W | Busy levels from the flash engine |
| err_src | input | ERR_W | Failure pulses from the flash engine |
| rdy_oe | output | 1 | Ready/busy pad output enable |
| rdy_val | output | 1 | Ready/busy pad output value |
| err_oe | output | 1 | Error pad output enable |
| err_val | output | 1 | Error pad output value |

## Verification
The assertions assume every instruction strobe and the chip reset last exactly one clock. They also assume failure pulses arrive only while the engine reports its result. None of them asks for strobes to be mutually exclusive, because the block defines a priority for each collision. The stimulus drives each strobe for one cycle, between falling edges. It deliberately overlaps enable with disable, and clear with a failure, so that the priority rules are exercised.

// File: rtl/isc_flags_pkg.sv
package isc_flags_pkg;

    typedef struct packed {
        logic oe;
        logic val;
    } pin_t;

    typedef struct packed {
        logic on;
        logic od;
    } mode_t;

    localparam int NUM_PINS = 2;
    localparam int PIN_RDY  = 0;
    localparam int PIN_ERR  = 1;

endpackage

// File: rtl/isc_mode_ctrl.sv
module isc_mode_ctrl
    import isc_flags_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_stb,
    input  logic dis_stb,
    input  logic od_sel,
    output logic isc_on,
    output logic od_mode
);

    mode_t mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        if (en_stb) begin
            mode_d.on = 1'b1;
            mode_d.od = od_sel;
        end
        if (dis_stb) begin
            mode_d.on = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= '0;
        else        mode_q <= mode_d;
    end

    assign isc_on  = mode_q.on;
    assign od_mode = mode_q.od;

    AST_DISABLE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        dis_stb |=> !isc_on); // R10
    AST_ENABLE_TURNS_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (en_stb && !dis_stb) |=> isc_on); // R2

endmodule

// File: rtl/isc_err_latch.sv
module isc_err_latch
    import isc_flags_pkg::*;
#(
    parameter int ERR_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ERR_W-1:0] err_src,
    input  logic             clr_stb,
    input  logic             chip_rst,
    input  logic             isc_on,
    output logic             err_flag
);

    logic flag_d, flag_q;
    logic fail_any;

    assign fail_any = |err_src;

    always_comb begin
        flag_d = flag_q;
        if (chip_rst && !isc_on) flag_d = 1'b0;
        if (clr_stb)             flag_d = 1'b0;
        if (fail_any)            flag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign err_flag = flag_q;

    AST_FAIL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        fail_any |=> err_flag); // R4
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stb && !fail_any) |=> !err_flag); // R5
    AST_RST_ON_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_rst && isc_on && !clr_stb && err_flag) |=> err_flag); // R6
    AST_RST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_rst && !isc_on && !fail_any) |=> !err_flag); // R7
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!chip_rst && !clr_stb && !fail_any) |=> $stable(err_flag)); // R9

endmodule

// File: rtl/isc_pin_drv.sv
module isc_pin_drv
    import isc_flags_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic isc_on,
    input  logic od_mode,
    output logic pin_oe,
    output logic pin_val
);

    pin_t pin_d, pin_q;

    always_comb begin
        if (!isc_on) begin
            pin_d.oe  = 1'b0;
            pin_d.val = 1'b1;
        end else if (od_mode) begin
            pin_d.oe  = active;
            pin_d.val = 1'b0;
        end else begin
            pin_d.oe  = 1'b1;
            pin_d.val = !active;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_q <= '{oe: 1'b0, val: 1'b1};
        else        pin_q <= pin_d;
    end

    assign pin_oe  = pin_q.oe;
    assign pin_val = pin_q.val;

    AST_RELEASED_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !isc_on |=> (!pin_oe && pin_val)); // R2
    AST_PP_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (isc_on && !od_mode) |=> pin_oe); // R3
    AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (isc_on && od_mode) |=> !pin_val); // R8

endmodule

// File: rtl/isc_flags.sv
module isc_flags
    import isc_flags_pkg::*;
#(
    parameter int BUSY_W = 2,
    parameter int ERR_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_stb,
    input  logic              dis_stb,
    input  logic              clr_stb,
    input  logic              od_sel,
    input  logic              chip_rst,
    input  logic [BUSY_W-1:0] busy_src,
    input  logic [ERR_W-1:0]  err_src,
    output logic              rdy_oe,
    output logic              rdy_val,
    output logic              err_oe,
    output logic              err_val
);

    logic                isc_on;
    logic                od_mode;
    logic                err_flag;
    logic [NUM_PINS-1:0] pin_active;
    logic [NUM_PINS-1:0] pin_oe;
    logic [NUM_PINS-1:0] pin_val;

    isc_mode_ctrl u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_stb  (en_stb),
        .dis_stb (dis_stb),
        .od_sel  (od_sel),
        .isc_on  (isc_on),
        .od_mode (od_mode)
    );

    isc_err_latch #(.ERR_W(ERR_W)) u_err (
        .clk      (clk),
        .rst_n    (rst_n),
        .err_src  (err_src),
        .clr_stb  (clr_stb),
        .chip_rst (chip_rst),
        .isc_on   (isc_on),
        .err_flag (err_flag)
    );

    assign pin_active[PIN_RDY] = |busy_src;
    assign pin_active[PIN_ERR] = err_flag;

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        isc_pin_drv u_drv (
            .clk     (clk),
            .rst_n   (rst_n),
            .active  (pin_active[g]),
            .isc_on  (isc_on),
            .od_mode (od_mode),
            .pin_oe  (pin_oe[g]),
            .pin_val (pin_val[g])
        );
    end

    assign rdy_oe  = pin_oe[PIN_RDY];
    assign rdy_val = pin_val[PIN_RDY];
    assign err_oe  = pin_oe[PIN_ERR];
    assign err_val = pin_val[PIN_ERR];

endmodule

// File: tb/isc_flags_test.sv
module isc_flags_test;

    localparam int BUSY_W = 2;
    localparam int ERR_W  = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              en_stb = 1'b0;
    logic              dis_stb = 1'b0;
    logic              clr_stb = 1'b0;
    logic              od_sel = 1'b0;
    logic              chip_rst = 1'b0;
    logic [BUSY_W-1:0] busy_src = '0;
    logic [ERR_W-1:0]  err_src = '0;
    logic              rdy_oe, rdy_val, err_oe, err_val;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    isc_flags #(.BUSY_W(BUSY_W), .ERR_W(ERR_W)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_stb   (en_stb),
        .dis_stb  (dis_stb),
        .clr_stb  (clr_stb),
        .od_sel   (od_sel),
        .chip_rst (chip_rst),
        .busy_src (busy_src),
        .err_src  (err_src),
        .rdy_oe   (rdy_oe),
        .rdy_val  (rdy_val),
        .err_oe   (err_oe),
        .err_val  (err_val)
    );

    task automatic check(input string req, input string what,
                         input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic check_pins(input string req, input logic roe, input logic rval,
                              input logic eoe, input logic eval);
        check(req, "rdy_oe",  rdy_oe,  roe);
        check(req, "rdy_val", rdy_val, rval);
        check(req, "err_oe",  err_oe,  eoe);
        check(req, "err_val", err_val, eval);
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic do_enable(input logic od);
        @(negedge clk); en_stb = 1'b1; od_sel = od;
        @(negedge clk); en_stb = 1'b0; od_sel = 1'b0;
        settle();
    endtask

    task automatic do_disable();
        @(negedge clk); dis_stb = 1'b1;
        @(negedge clk); dis_stb = 1'b0;
        settle();
    endtask

    task automatic do_clear();
        @(negedge clk); clr_stb = 1'b1;
        @(negedge clk); clr_stb = 1'b0;
        settle();
    endtask

    task automatic do_chip_rst();
        @(negedge clk); chip_rst = 1'b1;
        @(negedge clk); chip_rst = 1'b0;
        settle();
    endtask

    task automatic do_fail(input logic [ERR_W-1:0] src);
        @(negedge clk); err_src = src;
        @(negedge clk); err_src = '0;
        settle();
    endtask

    task automatic t_reset();
        check_pins("R1", 1'b0, 1'b1, 1'b0, 1'b1);
        check_pins("R2", 1'b0, 1'b1, 1'b0, 1'b1);
    endtask

    task automatic t_enable_pp();
        do_enable(1'b0);
        check_pins("R2", 1'b1, 1'b1, 1'b1, 1'b1); // R1: flag clear after reset
    endtask

    task automatic t_busy();
        @(negedge clk); busy_src = 2'b01; settle();
        check("R3", "rdy_val busy01", rdy_val, 1'b0);
        check("R3", "rdy_oe busy01",  rdy_oe,  1'b1);
        busy_src = 2'b10; settle();
        check("R3", "rdy_val busy10", rdy_val, 1'b0);
        busy_src = 2'b11; settle();
        check("R3", "rdy_val busy11", rdy_val, 1'b0);
        busy_src = 2'b00; settle();
        check("R3", "rdy_val idle",   rdy_val, 1'b1);
    endtask

    task automatic t_error();
        do_fail(2'b10);
        check("R4", "err_val set", err_val, 1'b0);
        repeat (5) @(negedge clk);
        check("R4", "err_val sticky", err_val, 1'b0);
        check("R4", "err_oe", err_oe, 1'b1);
    endtask

    task automatic t_rst_on();
        do_chip_rst();
        check("R6", "err_val after chip_rst on", err_val, 1'b0);
    endtask

    task automatic t_clear();
        do_clear();
        check("R5", "err_val cleared", err_val, 1'b1);
        @(negedge clk); clr_stb = 1'b1; err_src = 2'b01;
        @(negedge clk); clr_stb = 1'b0; err_src = '0;
        settle();
        check("R5", "fail beats clear", err_val, 1'b0);
    endtask

    task automatic t_disable_keep();
        do_disable();
        check_pins("R2", 1'b0, 1'b1, 1'b0, 1'b1);
        repeat (4) @(negedge clk);
        do_enable(1'b0);
        check("R9", "flag kept while off", err_val, 1'b0);
    endtask

    task automatic t_rst_off();
        do_disable();
        do_chip_rst();
        do_enable(1'b0);
        check("R7", "chip_rst while off clears", err_val, 1'b1);
    endtask

    task automatic t_open_drain();
        do_enable(1'b1);
        check_pins("R8", 1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk); busy_src = 2'b01; settle();
        check("R8", "rdy_oe busy od", rdy_oe, 1'b1);
        check("R8", "rdy_val busy od", rdy_val, 1'b0);
        busy_src = '0; settle();
        do_fail(2'b01);
        check("R8", "err_oe set od", err_oe, 1'b1);
        check("R8", "err_val set od", err_val, 1'b0);
        do_clear();
        check("R8", "err_oe cleared od", err_oe, 1'b0);
    endtask

    task automatic t_collide();
        @(negedge clk); en_stb = 1'b1; dis_stb = 1'b1;
        @(negedge clk); en_stb = 1'b0; dis_stb = 1'b0;
        settle();
        check_pins("R10", 1'b0, 1'b1, 1'b0, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        settle();
        t_reset();
        t_enable_pp();
        t_busy();
        t_error();
        t_rst_on();
        t_clear();
        t_disable_keep();
        t_rst_off();
        t_open_drain();
        t_collide();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule